// File: doc/BRIEF.md
# Fine-Time LFSR Interpolator

This block measures the fraction of an event-clock period between a hit and the following event-clock edge. A hit raises `start_i`, and the block then enables a local oscillator. Each oscillator period advances a 4-bit linear-feedback shift register by one state. When the next event-clock edge arrives, the coarse logic raises `stop_i`. The register then freezes, and the block decodes the frozen pattern into a binary count of oscillator periods.

In this model the oscillator is a free-running fast clock `clk_i`. Gating is expressed as an advance enable, and `osc_en_o` shows when the oscillator would be running. The measured value stays on `fine_o`, qualified by `fine_valid_o`, until the coarse readout issues `clear_i`. The event-clock window is about 14.5 oscillator periods long. The count therefore saturates at 14, and the saturation is reported on `overflow_o`.

Top module: `fti_interp`

## Requirements
- R1: After reset, `osc_en_o`, `fine_valid_o` and `overflow_o` are 0, `lfsr_o` holds the seed 4'b0001 and `fine_o` is 0.
- R2: A `start_i` sampled while idle raises `osc_en_o` on the next cycle, with `lfsr_o` still at the seed.
- R3: On each cycle that runs without stop, `lfsr_o` advances as a left shift with feedback bit3 XOR bit2 (x^4+x^3+1), so next = {q[2:0], q[3]^q[2]}. When it does not advance, it holds.
- R4: A `stop_i` sampled while running freezes `lfsr_o`. On the next cycle `osc_en_o` drops and `fine_valid_o` rises. `fine_o` equals the number of advance cycles between the start cycle and the stop cycle.
- R5: `fine_o` is always the binary number of steps from the seed to the present `lfsr_o` state (0001→0, 0010→1, 0100→2, 1001→3, …, 1000→14). `lfsr_o` is never 0.
- R6: If a run reaches 14 steps and another advance cycle follows without stop, the register holds at step 14 (4'b1000), `fine_o` stays 14 and `overflow_o` rises.
- R7: While `fine_valid_o` is high and no clear is given, the values on `fine_o`, `lfsr_o` and `overflow_o` stay constant and `fine_valid_o` stays high. This holds even if `start_i` or `stop_i` are asserted.
- R8: A `start_i` during a run is ignored: counting continues without restart.
- R9: `clear_i` returns the block to idle. It reloads the seed and drops `fine_valid_o` and `overflow_o`. `clear_i` takes precedence over a `start_i` in the same cycle.
- R10: A `stop_i` while idle has no effect: `osc_en_o` and `fine_valid_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock standing in for the oscillator |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Hit-derived start request |
| stop_i | input | 1 | Event-clock edge marker, ends the run |
| clear_i | input | 1 | Readout clear, re-arms the block |
| osc_en_o | output | 1 | Oscillator enable, high while running |
| lfsr_o | output | 4 | Raw shift-register state |
| fine_o | output | 4 | Decoded binary fine time |
| fine_valid_o | output | 1 | Measurement frozen and ready |
| overflow_o | output | 1 | Count clamped at 14 |

## Verification
The bench sweeps run lengths from 0 to beyond saturation. A decode table or step function that was wrong would show a mismatch between `fine_o` and the bench's own walk of the register. The 14/15 boundary is targeted directly: a design that wraps to the seed, or that flags overflow one step early, is caught there. Starts injected mid-run and pulses of start or stop after the freeze expose a design that restarts the count or disturbs a held result. A clear given together with a start checks that the clear wins rather than launching a new run.

// File: rtl/fti_pkg.sv
package fti_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } fti_state_e;

  // one Fibonacci step, left shift, feedback = parity of tapped bits
  function automatic logic [15:0] lfsr_adv(logic [15:0] q, logic [15:0] taps, int w);
    logic [15:0] mask;
    logic fb;
    mask = 16'((32'd1 << w) - 1);
    fb   = ^(q & taps & mask);
    return ((q << 1) | {15'd0, fb}) & mask;
  endfunction

  function automatic logic [15:0] lfsr_nth(logic [15:0] seed, logic [15:0] taps, int w, int k);
    logic [15:0] q;
    q = seed;
    for (int i = 0; i < k; i++) q = lfsr_adv(q, taps, w);
    return q;
  endfunction

endpackage

// File: rtl/fti_ctrl.sv
module fti_ctrl
  import fti_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       clear_i,
  input  logic       at_max_i,
  output fti_state_e state_o,
  output logic       load_o,
  output logic       adv_o,
  output logic       ovf_o
);

  fti_state_e state_q, state_d;
  logic       ovf_q, ovf_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN:  if (stop_i)  state_d = ST_DONE;
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
    if (clear_i) state_d = ST_IDLE;
  end

  // run cycle that would pass the window limit: hold and flag
  always_comb begin
    ovf_d = ovf_q;
    if (state_q == ST_RUN && !stop_i && at_max_i) ovf_d = 1'b1;
    if (clear_i) ovf_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ovf_q   <= ovf_d;
    end
  end

  assign load_o  = clear_i;
  assign adv_o   = (state_q == ST_RUN) && !stop_i && !clear_i && !at_max_i;
  assign state_o = state_q;
  assign ovf_o   = ovf_q;

  assert_done_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && !clear_i) |=> (state_q == ST_DONE));

  assert_no_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !stop_i && !clear_i) |=> (state_q == ST_RUN && !load_o || clear_i || state_q == ST_RUN));

  assert_idle_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> (state_q == ST_IDLE));

  assert_ovf_only_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> ($past(state_q) == ST_RUN));

endmodule

// File: rtl/fti_lfsr.sv
module fti_lfsr
  import fti_pkg::*;
#(
  parameter int          W    = 4,
  parameter logic [15:0] TAPS = 16'h000C,
  parameter logic [15:0] SEED = 16'h0001
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         adv_i,
  output logic [W-1:0] q_o
);

  localparam logic [W-1:0] SeedW = SEED[W-1:0];

  logic [W-1:0] q_q;
  logic [15:0]  nxt;

  assign nxt = lfsr_adv({{(16-W){1'b0}}, q_q}, TAPS, W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= SeedW;
    else if (load_i) q_q <= SeedW;
    else if (adv_i)  q_q <= nxt[W-1:0];
  end

  assign q_o = q_q;

  assert_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_q != '0);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(q_q));

endmodule

// File: rtl/fti_decode.sv
module fti_decode
  import fti_pkg::*;
#(
  parameter int          W    = 4,
  parameter logic [15:0] TAPS = 16'h000C,
  parameter logic [15:0] SEED = 16'h0001
) (
  input  logic [W-1:0] q_i,
  output logic [W-1:0] bin_o
);

  localparam int Period = (1 << W) - 1;

  logic [Period-1:0] hit;

  for (genvar i = 0; i < Period; i++) begin : g_match
    localparam logic [15:0] StI = lfsr_nth(SEED, TAPS, W, i);
    assign hit[i] = (q_i == StI[W-1:0]);
  end

  always_comb begin
    bin_o = '0;
    for (int i = 0; i < Period; i++)
      if (hit[i]) bin_o = bin_o | W'(i);
  end

  assert_onehot_R5: assert final ($onehot0(hit));

endmodule

// File: rtl/fti_interp.sv
module fti_interp
  import fti_pkg::*;
#(
  parameter int          LFSR_W    = 4,
  parameter logic [15:0] TAP_MASK  = 16'h000C,
  parameter logic [15:0] SEED      = 16'h0001,
  parameter int          MAX_STEPS = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              clear_i,
  output logic              osc_en_o,
  output logic [LFSR_W-1:0] lfsr_o,
  output logic [LFSR_W-1:0] fine_o,
  output logic              fine_valid_o,
  output logic              overflow_o
);

  localparam logic [15:0] MaxState = lfsr_nth(SEED, TAP_MASK, LFSR_W, MAX_STEPS);

  fti_state_e  state;
  logic        load, adv, ovf, at_max;
  logic [LFSR_W-1:0] q;

  assign at_max = (q == MaxState[LFSR_W-1:0]);

  fti_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .clear_i  (clear_i),
    .at_max_i (at_max),
    .state_o  (state),
    .load_o   (load),
    .adv_o    (adv),
    .ovf_o    (ovf)
  );

  fti_lfsr #(.W(LFSR_W), .TAPS(TAP_MASK), .SEED(SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .adv_i  (adv),
    .q_o    (q)
  );

  fti_decode #(.W(LFSR_W), .TAPS(TAP_MASK), .SEED(SEED)) u_dec (
    .q_i   (q),
    .bin_o (fine_o)
  );

  assign osc_en_o     = (state == ST_RUN);
  assign fine_valid_o = (state == ST_DONE);
  assign overflow_o   = ovf;
  assign lfsr_o       = q;

  assert_clamp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> (fine_o == LFSR_W'(MAX_STEPS)));

  assert_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fine_valid_o && !clear_i) |=> $stable(lfsr_o) && $stable(overflow_o));

  assert_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(osc_en_o && fine_valid_o));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!osc_en_o && !fine_valid_o && !overflow_o));

endmodule

// File: tb/fti_interp_tb.sv
module fti_interp_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, clear = 1'b0;
  logic osc_en, fine_valid, overflow;
  logic [3:0] lfsr, fine;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fti_interp dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .stop_i       (stop),
    .clear_i      (clear),
    .osc_en_o     (osc_en),
    .lfsr_o       (lfsr),
    .fine_o       (fine),
    .fine_valid_o (fine_valid),
    .overflow_o   (overflow)
  );

  function automatic logic [3:0] step_m(logic [3:0] q);
    return {q[2:0], q[3] ^ q[2]};
  endfunction

  function automatic logic [3:0] state_at(int k);
    logic [3:0] q = 4'b0001;
    for (int i = 0; i < k; i++) q = step_m(q);
    return q;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // n advance cycles between start and stop; optional mid-run starts
  task automatic measure(int n, bit noise);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R2 osc_en", osc_en, 1);
    check("R2 seed", lfsr, 1);
    for (int i = 0; i < n; i++) begin
      start = noise && (i % 3 == 1);
      @(negedge clk);
    end
    start = 1'b0;
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    check("R4 valid", fine_valid, 1);
    check("R4 osc_en off", osc_en, 0);
    check("R4 R8 fine", fine, (n > 14) ? 14 : n);
    check("R3 lfsr", lfsr, state_at((n > 14) ? 14 : n));
    check("R6 overflow", overflow, (n > 14) ? 1 : 0);
  endtask

  task automatic hold_probe(int exp_fine, int exp_ovf);
    start = 1'b1; stop = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0; stop = 1'b0;
    check("R7 valid held", fine_valid, 1);
    check("R7 fine held", fine, exp_fine);
    check("R7 ovf held", overflow, exp_ovf);
  endtask

  task automatic do_clear(bit with_start);
    clear = 1'b1; start = with_start;
    @(negedge clk); clear = 1'b0; start = 1'b0;
    check("R9 idle", osc_en, 0);
    check("R9 valid", fine_valid, 0);
    check("R9 ovf", overflow, 0);
    check("R9 seed", lfsr, 1);
  endtask

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    check("R1 osc_en", osc_en, 0);
    check("R1 valid", fine_valid, 0);
    check("R1 ovf", overflow, 0);
    check("R1 lfsr", lfsr, 1);
    check("R1 fine", fine, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: stop while idle
    stop = 1'b1;
    repeat (2) @(negedge clk);
    stop = 1'b0;
    check("R10 osc_en", osc_en, 0);
    check("R10 valid", fine_valid, 0);

    // R5: full decode walk, one run per length
    for (int k = 0; k <= 14; k++) begin
      measure(k, 1'b0);
      check("R5 decode", fine, k);
      do_clear(1'b0);
    end

    // R6 boundary around saturation
    measure(15, 1'b0);
    hold_probe(14, 1);
    do_clear(1'b1);
    measure(22, 1'b1);
    do_clear(1'b0);

    // random runs
    for (int it = 0; it < 40; it++) begin
      n = int'($urandom_range(0, 20));
      measure(n, 1'(($urandom() & 1)));
      hold_probe((n > 14) ? 14 : n, (n > 14) ? 1 : 0);
      do_clear(1'(($urandom() & 1)));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule